// File: doc/BRIEF.md
# Concurrent Write Resolver

When several processors write the same shared memory word in one cycle, this block reduces their requests to a single store. Each of N request lanes carries a valid bit and a data word. A run-time mode input selects how competing values are merged. The choices are:

- store a reserved collision code
- require agreement among the writers
- let the lowest-numbered lane win
- take the largest or the smallest value
- fold the values by sum, AND or XOR
- pick one writer pseudo-randomly

The block registers its result. One cycle after the requests it presents a write-enable, the merged word and a flag that reports a collision. The flag is raised whenever more than one lane wrote. Grouping the lanes by target address is done upstream of this block, and the memory array lies downstream of it.

Top module: `cw_resolver`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, `wr_en` and `collide` are 0 and `wr_data` is 0.
- R2: Outputs reflect the requests sampled at the previous rising edge. With no lane valid, `wr_en` is 0 in the next cycle.
- R3: When exactly one lane is valid, every mode code stores that lane's word unchanged, with `wr_en` high and `collide` low.
- R4: `collide` is high in the cycle after two or more lanes are valid, and low otherwise, whatever the mode.
- R5: Mode code 0 (detect): when two or more lanes are valid, the stored word is the parameter `COLL_CODE`, which defaults to all ones.
- R6: Mode code 1 (agree): the word is stored only if all valid lanes offer the same value. If any two of them differ, `wr_en` is 0.
- R7: Mode code 2 (lowest index) stores the word of the valid lane with the smallest index. The unassigned codes 9 to 15 behave the same way.
- R8: Mode codes 3 and 4 store the largest and the smallest valid word respectively, comparing the words as unsigned numbers.
- R9: Mode code 5 stores the sum of all valid words modulo 2^W.
- R10: Mode code 6 stores the bitwise AND of all valid words. Mode code 7 stores their bitwise XOR.
- R11: Mode code 8 (random) stores the word of one of the valid lanes, chosen by a free-running LFSR, with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Merge policy code |
| lane_valid | input | LANES | Per-lane write request |
| lane_data | input | LANES*W | Lane words; lane i occupies bits [i*W +: W] |
| wr_en | output | 1 | Registered store enable |
| wr_data | output | W | Registered merged word |
| collide | output | 1 | Registered flag: two or more writers |

## Verification
The bench builds the block with five lanes of 8-bit data. An odd lane count makes the random start index wrap around a lane count that is not a power of two. Narrow words make the sum overflow often, and they make a legitimate 0xFF value coincide with the default collision code. Random traffic is forced to share equal words at times, so the agree mode also produces successful stores and not only rejections. The unassigned mode codes are reached as well.

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int LANES = 4,
  parameter int W = 8,
  parameter logic [W-1:0] COLL_CODE = '1,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         mode,
  input  logic [LANES-1:0]   lane_valid,
  input  logic [LANES*W-1:0] lane_data,
  output logic               wr_en,
  output logic [W-1:0]       wr_data,
  output logic               collide
);
  localparam logic [3:0] M_DETECT = 4'd0;
  localparam logic [3:0] M_AGREE  = 4'd1;
  localparam logic [3:0] M_MAX    = 4'd3;
  localparam logic [3:0] M_MIN    = 4'd4;
  localparam logic [3:0] M_SUM    = 4'd5;
  localparam logic [3:0] M_AND    = 4'd6;
  localparam logic [3:0] M_XOR    = 4'd7;
  localparam logic [3:0] M_RAND   = 4'd8;

  logic [15:0]  lfsr;
  int           cnt;
  logic         agree;
  logic [W-1:0] first, vmax, vmin, vsum, vand, vxor, rpick;
  logic         nxt_en;
  logic [W-1:0] nxt_data;

  always_comb begin
    cnt = 0; agree = 1'b1; first = '0;
    vmax = '0; vmin = '1; vsum = '0; vand = '1; vxor = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_valid[i]) begin
        if (cnt == 0) first = lane_data[i*W +: W];
        else if (lane_data[i*W +: W] != first) agree = 1'b0;
        cnt = cnt + 1;
        if (lane_data[i*W +: W] > vmax) vmax = lane_data[i*W +: W];
        if (lane_data[i*W +: W] < vmin) vmin = lane_data[i*W +: W];
        vsum = vsum + lane_data[i*W +: W];
        vand = vand & lane_data[i*W +: W];
        vxor = vxor ^ lane_data[i*W +: W];
      end
    end
  end

  always_comb begin
    int start, idx;
    logic got;
    start = int'(lfsr) % LANES;
    got = 1'b0;
    rpick = '0;
    for (int k = 0; k < LANES; k++) begin
      idx = start + k;
      if (idx >= LANES) idx = idx - LANES;
      if (!got && lane_valid[idx]) begin
        rpick = lane_data[idx*W +: W];
        got = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_en = (cnt != 0);
    case (mode)
      M_DETECT: nxt_data = (cnt > 1) ? COLL_CODE : first;
      M_AGREE: begin
        nxt_data = first;
        nxt_en = (cnt != 0) && agree;
      end
      M_MAX:  nxt_data = vmax;
      M_MIN:  nxt_data = vmin;
      M_SUM:  nxt_data = vsum;
      M_AND:  nxt_data = vand;
      M_XOR:  nxt_data = vxor;
      M_RAND: nxt_data = rpick;
      default: nxt_data = first;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= LFSR_SEED;
      wr_en   <= 1'b0;
      wr_data <= '0;
      collide <= 1'b0;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_en   <= nxt_en;
      wr_data <= nxt_en ? nxt_data : '0;
      collide <= (cnt > 1);
    end
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (lane_valid == '0) |=> !wr_en);
  p_collide_set_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_valid) >= 2) |=> collide);
  p_collide_clr_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_valid) < 2) |=> !collide);
  p_detect_code_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DETECT && $countones(lane_valid) >= 2) |=> (wr_en && wr_data == COLL_CODE));
  p_rand_store_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RAND && lane_valid != '0) |=> wr_en);
endmodule

// File: tb/cw_resolver_test.sv
module cw_resolver_test;
  localparam int N = 5;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  logic [3:0] mode = '0;
  logic [N-1:0] lane_valid = '0;
  logic [N*W-1:0] lane_data = '0;
  logic wr_en, collide;
  logic [W-1:0] wr_data;
  int checks = 0, fails = 0;
  bit done = 0;

  cw_resolver #(.LANES(N), .W(W)) uut (
    .clk(clk), .rst(rst), .mode(mode), .lane_valid(lane_valid),
    .lane_data(lane_data), .wr_en(wr_en), .wr_data(wr_data), .collide(collide));

  always #5 clk = ~clk;

  function automatic logic [W-1:0] lane(input logic [N*W-1:0] d, input int i);
    return d[i*W +: W];
  endfunction

  function automatic void model(input logic [3:0] m, input logic [N-1:0] v,
      input logic [N*W-1:0] d, output bit en, output logic [W-1:0] val, output bit col);
    int n, acc;
    logic [W-1:0] lo;
    bit same;
    n = 0; acc = 0; lo = '0; same = 1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) begin n++; lo = lane(d, i); end
    for (int i = 0; i < N; i++) if (v[i] && lane(d, i) != lo) same = 0;
    col = (n >= 2);
    en = (n > 0);
    val = lo;
    case (m)
      4'd0: if (n >= 2) val = 8'hFF;
      4'd1: en = (n > 0) && same;
      4'd3: begin val = 0; for (int i = 0; i < N; i++) if (v[i] && lane(d, i) > val) val = lane(d, i); end
      4'd4: begin val = 8'hFF; for (int i = 0; i < N; i++) if (v[i] && lane(d, i) < val) val = lane(d, i); end
      4'd5: begin for (int i = 0; i < N; i++) if (v[i]) acc += int'(lane(d, i)); val = W'(acc % 256); end
      4'd6: begin val = 8'hFF; for (int i = 0; i < N; i++) if (v[i]) val &= lane(d, i); end
      4'd7: begin val = 0; for (int i = 0; i < N; i++) if (v[i]) val ^= lane(d, i); end
      default: ;
    endcase
  endfunction

  task automatic step(input logic [3:0] m, input logic [N-1:0] v,
      input logic [N*W-1:0] d, input string tag);
    bit en, col, ok;
    logic [W-1:0] val;
    mode = m; lane_valid = v; lane_data = d;
    model(m, v, d, en, val, col);
    @(negedge clk);
    checks++;
    ok = (wr_en == en) && (collide == col);
    if (ok && en) begin
      if (m == 4'd8) begin
        ok = 0;
        for (int i = 0; i < N; i++) if (v[i] && lane(d, i) == wr_data) ok = 1;
      end else ok = (wr_data == val);
    end
    if (!ok) begin
      fails++;
      $display("FAIL %s mode=%0d valid=%b: actual en=%0b data=%h col=%0b expected en=%0b data=%h col=%0b",
               tag, m, v, wr_en, wr_data, collide, en, val, col);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] d;
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    checks++;
    if (wr_en !== 0 || collide !== 0 || wr_data !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual en=%b col=%b data=%h expected 0 0 00", wr_en, collide, wr_data);
    end
    rst = 0;
    d = {8'h11, 8'h80, 8'hC8, 8'h64, 8'h2A};
    step(4'd3, '0, d, "R2 idle");
    checks++;
    if (wr_en !== 0 || collide !== 0 || wr_data !== 0) begin
      fails++;
      $display("FAIL R1 first cycle after reset: actual en=%b col=%b data=%h expected 0 0 00", wr_en, collide, wr_data);
    end
    for (int m = 0; m < 16; m++) step(4'(m), 5'b00100, d, "R3 single lane");
    step(4'd0, 5'b00110, d, "R5 detect");
    step(4'd0, 5'b11111, {N{8'hFF}}, "R5 detect all ones");
    step(4'd1, 5'b10101, {N{8'h3C}}, "R6 agree equal");
    step(4'd1, 5'b10101, d, "R6 agree differ");
    step(4'd2, 5'b10100, d, "R7 lowest index");
    step(4'd12, 5'b11010, d, "R7 unassigned code");
    step(4'd3, 5'b01111, d, "R8 max");
    step(4'd4, 5'b11110, d, "R8 min");
    step(4'd5, 5'b00110, d, "R9 sum wrap");
    step(4'd6, 5'b10011, d, "R10 and");
    step(4'd7, 5'b11111, d, "R10 xor");
    step(4'd8, 5'b10001, d, "R11 random");
    step(4'd4, '0, d, "R4 idle no collide");
    void'($urandom(32'd2024));
    for (int t = 0; t < 600; t++) begin
      v = N'($urandom);
      for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
      if ($urandom % 4 == 0) d = {N{d[W-1:0]}};
      step(4'($urandom), v, d, "R4 random traffic");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule